// File: doc/BRIEF.md
# Vertical Sync Detector and Field Separator

This block finds the vertical sync interval inside a composite sync stream. The stream is sampled once per half line, on a strobe that runs at twice the horizontal rate, so that horizontal sync and equalizing pulses are too short to be caught twice in a row. A long low stretch is taken as vertical sync. The half-line phase at which that stretch begins, whole line or mid line, is recorded for each field.

Comparing that phase from field to field tells the block whether the source is interlaced and which field is on screen. It reports an interlace flag, an active-low field-one flag and an active-low frame-start strobe. A select input picks the composite sync source, either the horizontal-sync pin or the sync recovered from the green channel. A last output multiplexer passes either the internally detected vertical sync and field flag or an externally supplied pair.

Top module: `vsync_field_sep`

## Requirements
- R1: `src_sel` = 0 samples `csync_hs` and `src_sel` = 1 samples `csync_sog`. The unselected input has no effect on any output.
- R2: Composite sync is sampled only at a clock edge where `half_tick` = 1. `vsync_det` rises one clock after the edge that takes the second consecutive low sample. A single low sample, such as an equalizing pulse, never raises it.
- R3: `vsync_det` falls one clock after the first `half_tick` edge that samples the selected sync high.
- R4: The phase of a vertical sync onset is the value of `line_phase` at its first low sample. The value 0 means the whole-line phase and 1 means the mid-line phase.
- R5: At an onset whose phase differs from the previous onset's phase, `interlace` becomes 1 one clock after that onset edge.
- R6: `interlace` clears after four successive onsets share one phase, which is three equal comparisons in a row. Two equal comparisons after an interlaced run leave it at 1.
- R7: `field1_n` is 0 only while `interlace` = 1 and the latest onset phase was whole-line. Otherwise it is 1.
- R8: `frame_start_n` is low for exactly one clock, starting one clock after an onset edge. It pulses at every onset while non-interlaced, and only at whole-line onsets while interlaced. The interlace value used is the one updated at that same onset.
- R9: `vmux_sel` = 1 drives `vsync_out` from `ext_vsync` and `field_out_n` from `ext_field_n`. `vmux_sel` = 0 drives them from `vsync_det` and `field1_n`.
- R10: While `rst` is high, the next clock leaves `vsync_det` = 0, `interlace` = 0, `field1_n` = 1 and `frame_start_n` = 1.
- R11: A low level on the selected sync between half-line strobes does not change `vsync_det`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-clock strobe at twice the horizontal rate |
| line_phase | input | 1 | Phase of the current strobe: 0 is whole line, 1 is mid line |
| csync_hs | input | 1 | Composite sync from the horizontal-sync pin |
| csync_sog | input | 1 | Composite sync recovered from green |
| src_sel | input | 1 | Sync source select: 0 is csync_hs, 1 is csync_sog |
| ext_vsync | input | 1 | External vertical sync |
| ext_field_n | input | 1 | External active-low field-one flag |
| vmux_sel | input | 1 | Output select: 1 is external, 0 is internal |
| vsync_det | output | 1 | Detected vertical sync |
| interlace | output | 1 | High when the source is interlaced |
| field1_n | output | 1 | Low while field one is current |
| frame_start_n | output | 1 | One-clock low strobe at a new frame |
| vsync_out | output | 1 | Selected vertical sync |
| field_out_n | output | 1 | Selected field-one flag |

## Verification
The bench sends single low samples right after vertical sync and short lows between strobes. A detector that counted one sample as enough, or that watched every clock, would report false vertical syncs there. It runs an interlaced sequence followed by a run of same-phase fields. A design without the hysteresis would drop `interlace` after one repeat. A design that picked the wrong field, or that tested frame start against the stale interlace value, would pulse `frame_start_n` at mid-line onsets. It also switches the sync source and the output multiplexer while the unselected inputs toggle, to expose a swapped or leaky select.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    typedef enum logic {
        PH_WHOLE = 1'b0,
        PH_HALF  = 1'b1
    } phase_e;

    typedef struct packed {
        logic   fire;
        phase_e phase;
    } onset_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vsf_sampler.sv
module vsf_sampler
    import vsf_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   half_tick,
    input  logic   line_phase,
    input  logic   csync_hs,
    input  logic   csync_sog,
    input  logic   src_sel,
    output onset_t onset,
    output logic   vsync_det
);
    localparam int RUN_W = $clog2(MIN_LOW + 1);

    logic             sel_sync;
    logic [RUN_W-1:0] low_run;
    phase_e           first_ph;

    assign sel_sync = src_sel ? csync_sog : csync_hs;

    always_comb begin
        onset.fire  = half_tick && !sel_sync && (low_run == RUN_W'(MIN_LOW - 1));
        onset.phase = (low_run == '0) ? phase_e'(line_phase) : first_ph;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= '0;
            first_ph  <= PH_WHOLE;
            vsync_det <= 1'b0;
        end else if (half_tick) begin
            if (sel_sync) begin
                low_run   <= '0;
                vsync_det <= 1'b0;
            end else begin
                if (low_run == '0)
                    first_ph <= phase_e'(line_phase);
                if (low_run != RUN_W'(MIN_LOW))
                    low_run <= low_run + 1'b1;
                if (onset.fire)
                    vsync_det <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vsf_classifier.sv
module vsf_classifier
    import vsf_pkg::*;
#(
    parameter int ALT_FIELDS  = 2,
    parameter int SAME_FIELDS = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  onset_t onset,
    output logic   interlace,
    output logic   field1_n,
    output logic   frame_start_n
);
    localparam int ALT_CHG  = ALT_FIELDS - 1;
    localparam int SAME_CHG = SAME_FIELDS - 1;
    localparam int CNT_W    = $clog2(max2(ALT_CHG, SAME_CHG) + 1);

    logic             have_prev;
    phase_e           prev_ph;
    phase_e           cur_ph;
    logic [CNT_W-1:0] alt_cnt, alt_nx;
    logic [CNT_W-1:0] same_cnt, same_nx;
    logic             il_nx;

    always_comb begin
        alt_nx  = alt_cnt;
        same_nx = same_cnt;
        il_nx   = interlace;
        if (have_prev) begin
            if (onset.phase != prev_ph) begin
                same_nx = '0;
                if (alt_cnt != CNT_W'(ALT_CHG))
                    alt_nx = alt_cnt + 1'b1;
                if (alt_nx >= CNT_W'(ALT_CHG))
                    il_nx = 1'b1;
            end else begin
                alt_nx = '0;
                if (same_cnt != CNT_W'(SAME_CHG))
                    same_nx = same_cnt + 1'b1;
                if (same_nx >= CNT_W'(SAME_CHG))
                    il_nx = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev     <= 1'b0;
            prev_ph       <= PH_WHOLE;
            cur_ph        <= PH_WHOLE;
            alt_cnt       <= '0;
            same_cnt      <= '0;
            interlace     <= 1'b0;
            frame_start_n <= 1'b1;
        end else if (onset.fire) begin
            have_prev     <= 1'b1;
            prev_ph       <= onset.phase;
            cur_ph        <= onset.phase;
            alt_cnt       <= alt_nx;
            same_cnt      <= same_nx;
            interlace     <= il_nx;
            frame_start_n <= !(!il_nx || onset.phase == PH_WHOLE);
        end else begin
            frame_start_n <= 1'b1;
        end
    end

    assign field1_n = !(interlace && cur_ph == PH_WHOLE);

endmodule

// File: rtl/vsf_out_mux.sv
module vsf_out_mux (
    input  logic vmux_sel,
    input  logic int_vsync,
    input  logic int_field_n,
    input  logic ext_vsync,
    input  logic ext_field_n,
    output logic vsync_out,
    output logic field_out_n
);
    always_comb begin
        if (vmux_sel) begin
            vsync_out   = ext_vsync;
            field_out_n = ext_field_n;
        end else begin
            vsync_out   = int_vsync;
            field_out_n = int_field_n;
        end
    end
endmodule

// File: rtl/vsync_field_sep.sv
module vsync_field_sep
    import vsf_pkg::*;
#(
    parameter int MIN_LOW     = 2,
    parameter int ALT_FIELDS  = 2,
    parameter int SAME_FIELDS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic half_tick,
    input  logic line_phase,
    input  logic csync_hs,
    input  logic csync_sog,
    input  logic src_sel,
    input  logic ext_vsync,
    input  logic ext_field_n,
    input  logic vmux_sel,
    output logic vsync_det,
    output logic interlace,
    output logic field1_n,
    output logic frame_start_n,
    output logic vsync_out,
    output logic field_out_n
);
    onset_t onset;

    vsf_sampler #(.MIN_LOW(MIN_LOW)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .line_phase(line_phase),
        .csync_hs  (csync_hs),
        .csync_sog (csync_sog),
        .src_sel   (src_sel),
        .onset     (onset),
        .vsync_det (vsync_det)
    );

    vsf_classifier #(.ALT_FIELDS(ALT_FIELDS), .SAME_FIELDS(SAME_FIELDS)) u_class (
        .clk          (clk),
        .rst          (rst),
        .onset        (onset),
        .interlace    (interlace),
        .field1_n     (field1_n),
        .frame_start_n(frame_start_n)
    );

    vsf_out_mux u_mux (
        .vmux_sel   (vmux_sel),
        .int_vsync  (vsync_det),
        .int_field_n(field1_n),
        .ext_vsync  (ext_vsync),
        .ext_field_n(ext_field_n),
        .vsync_out  (vsync_out),
        .field_out_n(field_out_n)
    );

endmodule

// File: rtl/vsync_field_sep_chk.sv
module vsync_field_sep_chk (
    input logic clk,
    input logic rst,
    input logic half_tick,
    input logic src_sel,
    input logic csync_hs,
    input logic csync_sog,
    input logic vsync_det,
    input logic interlace,
    input logic field1_n,
    input logic frame_start_n
);
    // R2: vertical sync can only start at a sampling strobe
    p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_det) |-> $past(half_tick));

    // R3: vertical sync ends only after a high sample at a strobe
    p_fall_on_high_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_det) |-> ($past(half_tick) && $past(src_sel ? csync_sog : csync_hs)));

    // R11: nothing moves between strobes
    p_quiet_between_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(half_tick) |-> $stable(vsync_det));

    // R5: interlace only changes at a vertical sync onset
    p_il_at_onset_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(interlace) |-> $rose(vsync_det));

    // R7: field one is never flagged for a progressive source
    p_field1_needs_il_r7: assert property (@(posedge clk) disable iff (rst)
        !field1_n |-> interlace);

    // R8: frame start is a single-clock strobe aligned with an onset
    p_fs_width_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start_n |=> frame_start_n);
    p_fs_at_onset_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_start_n |-> $rose(vsync_det));

    // R10: reset leaves every flag idle
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!vsync_det && !interlace && field1_n && frame_start_n));
endmodule

bind vsync_field_sep vsync_field_sep_chk u_chk (.*);

// File: tb/vsync_field_sep_bench.sv
`timescale 1ns/1ps
module vsync_field_sep_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic half_tick = 1'b0, line_phase = 1'b0;
    logic csync_hs = 1'b1, csync_sog = 1'b1, src_sel = 1'b0;
    logic ext_vsync = 1'b0, ext_field_n = 1'b1, vmux_sel = 1'b0;
    logic vsync_det, interlace, field1_n, frame_start_n, vsync_out, field_out_n;

    int checks = 0, failures = 0, fs_count = 0;
    bit ph = 1'b0;
    bit started = 1'b0;

    // reference model state
    int m_run = 0, m_first = 0, m_vs = 0, m_il = 0, m_have = 0, m_prev = 0;
    int m_cur = 0, m_alt = 0, m_same = 0, m_fs = 1;

    always #4 clk = ~clk;

    vsync_field_sep u_vsync_field_sep (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_first = 0; m_vs = 0; m_il = 0; m_have = 0;
            m_prev = 0; m_cur = 0; m_alt = 0; m_same = 0; m_fs = 1;
        end else begin
            int s;
            s = src_sel ? csync_sog : csync_hs;
            m_fs = 1;
            if (half_tick) begin
                if (s != 0) begin
                    m_run = 0; m_vs = 0;
                end else begin
                    if (m_run == 0) m_first = line_phase;
                    m_run++;
                    if (m_run == 2) begin
                        m_vs = 1;
                        if (m_have != 0) begin
                            if (m_first != m_prev) begin
                                m_same = 0; m_alt++;
                                if (m_alt >= 1) m_il = 1;
                            end else begin
                                m_alt = 0; m_same++;
                                if (m_same >= 3) m_il = 0;
                            end
                        end
                        m_have = 1; m_prev = m_first; m_cur = m_first;
                        m_fs = (m_il != 0 && m_first == 1) ? 1 : 0;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !rst) begin
            int e_f1;
            e_f1 = (m_il != 0 && m_cur == 0) ? 0 : 1;
            chk(vsync_det == m_vs, "R2/R3", "vsync_det", vsync_det, m_vs);
            chk(interlace == m_il, "R5", "interlace", interlace, m_il);
            chk(field1_n == e_f1, "R7", "field1_n", field1_n, e_f1);
            chk(frame_start_n == m_fs, "R8", "frame_start_n", frame_start_n, m_fs);
            chk(vsync_out == (vmux_sel ? ext_vsync : m_vs), "R9", "vsync_out",
                vsync_out, vmux_sel ? ext_vsync : m_vs);
            chk(field_out_n == (vmux_sel ? ext_field_n : e_f1), "R9", "field_out_n",
                field_out_n, vmux_sel ? ext_field_n : e_f1);
            if (!frame_start_n) fs_count++;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // one half line: a short low between strobes on the hs pin, then the strobe
    task automatic tick(input bit hs_lvl, input bit sog_lvl);
        csync_hs = hs_lvl; csync_sog = sog_lvl;
        step();
        if (hs_lvl) csync_hs = 1'b0;
        step();
        csync_hs = hs_lvl;
        step();
        half_tick = 1'b1; line_phase = ph;
        step();
        half_tick = 1'b0;
        ph = ~ph;
    endtask

    task automatic field(input bit want);
        while (ph != want) tick(1'b1, 1'b1);
        repeat (3) tick(1'b0, 1'b0);
        tick(1'b1, 1'b1);
        tick(1'b0, 1'b0);
        repeat (5) tick(1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) step();
        // R10: reset state
        chk(vsync_det == 0 && interlace == 0 && field1_n == 1 && frame_start_n == 1,
            "R10", "idle flags", {vsync_det, interlace, field1_n, frame_start_n}, 4'b0011);
        rst = 1'b0;
        started = 1'b1;

        // R11: lows between strobes alone never raise vertical sync
        repeat (6) tick(1'b1, 1'b1);
        chk(vsync_det == 0, "R11", "vsync_det after inter-strobe lows", vsync_det, 0);

        // R2: one low sample is not vertical sync
        tick(1'b0, 1'b0);
        step();
        chk(vsync_det == 0, "R2", "vsync_det after single low", vsync_det, 0);
        tick(1'b1, 1'b1);

        // interlaced run: whole, half, whole, half
        fs_count = 0;
        field(1'b0);
        chk(interlace == 0, "R5", "interlace after first field", interlace, 0);
        field(1'b1);
        chk(interlace == 1, "R5", "interlace after phase change", interlace, 1);
        chk(field1_n == 1, "R4", "field1_n after mid-line onset", field1_n, 1);
        field(1'b0);
        chk(field1_n == 0, "R4", "field1_n after whole-line onset", field1_n, 0);
        field(1'b1);
        chk(fs_count == 2, "R8", "frame starts over four fields", fs_count, 2);

        // hysteresis and clearing with mid-line onsets
        fs_count = 0;
        field(1'b1);
        field(1'b1);
        chk(interlace == 1, "R6", "interlace after two repeats", interlace, 1);
        chk(fs_count == 0, "R8", "no frame start at interlaced mid-line", fs_count, 0);
        field(1'b1);
        chk(interlace == 0, "R6", "interlace after three repeats", interlace, 0);
        chk(fs_count == 1, "R8", "frame start once progressive", fs_count, 1);
        chk(vsync_det == 0, "R3", "vsync_det after high samples", vsync_det, 0);

        // R1: source select
        src_sel = 1'b1;
        repeat (3) tick(1'b0, 1'b1);
        chk(vsync_det == 0, "R1", "hs lows ignored with sog selected", vsync_det, 0);
        repeat (2) tick(1'b1, 1'b0);
        step();
        chk(vsync_det == 1, "R1", "sog lows detected", vsync_det, 1);
        repeat (3) tick(1'b1, 1'b1);
        src_sel = 1'b0;

        // R9: output multiplexer
        vmux_sel = 1'b1; ext_vsync = 1'b1; ext_field_n = 1'b0;
        step();
        chk(vsync_out == 1 && field_out_n == 0, "R9", "external pair",
            {vsync_out, field_out_n}, 2'b10);
        field(1'b0);
        ext_vsync = 1'b0; ext_field_n = 1'b1;
        step();
        chk(vsync_out == 0 && field_out_n == 1, "R9", "external pair swapped",
            {vsync_out, field_out_n}, 2'b01);
        vmux_sel = 1'b0;
        step();
        chk(vsync_out == vsync_det, "R9", "internal vsync", vsync_out, vsync_det);

        repeat (4) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule